// File: doc/BRIEF.md
# Prioritised Five-Source Interrupt Vector Controller

This block sits beside a small 8-bit processor core and arbitrates among five interrupt request lines. At every instruction boundary it decides whether a request may be taken and which one wins. It then issues a one-cycle acknowledge strobe that carries a 16-bit service-routine address and a source code. One line is non-maskable and needs a fresh rising edge. Three lines have fixed addresses and can be masked individually. The fifth line has no fixed address: the interrupting device supplies a restart opcode byte over a small valid/ready stream, and the address is computed from that byte.

A single global enable flag gates every source except the non-maskable one. The core sets and clears this flag with plain command strobes. A 3-bit mask register is written through a strobe with data. The highest fixed-vector line is edge-triggered, and it has a pending latch that keeps a request which arrived while the line was masked. A separate strobe clears that latch. The byte stream follows one back-pressure rule: `bus_ready` is high only while the block is waiting for a restart byte. A byte is consumed on the cycle where `bus_valid` and `bus_ready` are both high. While `bus_ready` is low, `bus_valid` and `bus_data` are ignored, and the device may hold `bus_valid` for as long as it likes.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset the global enable is clear, all three mask bits are set, the edge latch is empty, and `irq_o`, `ack_o` and `bus_ready` are low.
- R2: `cmd_ei` sets the global enable and `cmd_di` clears it; `cmd_ei` wins if both are high. While the enable is clear, no maskable source raises `irq_o`.
- R3: `mask_wr` loads `mask_data`: bit 0 masks source FX0, bit 1 masks FX1, bit 2 masks FX2, and a 1 means masked.
- R4: Accepted fixed sources report these addresses and source codes: FX0 0x002C code 4, FX1 0x0034 code 3, FX2 0x003C code 2.
- R5: NMI ignores the enable and the masks. It is eligible only while its input is high and after a rising edge of that input. It reports 0x0024, code 1. Holding the input high after service does not trigger it again.
- R6: When several sources are eligible at once, the winner follows this order: NMI, FX2, FX1, FX0, DEV.
- R7: A rising edge on FX2 is latched even while FX2 is masked or the enable is clear. Once the mask and enable allow it, the latch raises the interrupt even if the input has already fallen.
- R8: The FX2 latch is cleared when FX2 is accepted or when `clr_fx2` is pulsed. A new rising edge in the same cycle wins over the clear.
- R9: A request is accepted only in a cycle where `insn_done` is high. `ack_o` pulses in the following cycle. FX1, FX0 and DEV are level-sensitive.
- R10: Accepting DEV raises `bus_ready` and holds it until a byte is taken. The address is `bus_data[5:3]` times 8, reported with code 5 in the cycle after the handshake. Nothing else is accepted during the wait, and `irq_o` stays low.
- R11: Accepting any maskable source clears the global enable, and this overrides a `cmd_ei` in the same cycle. Accepting NMI leaves the enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, level plus edge |
| fx2_req | input | 1 | Fixed-vector request, edge-latched |
| fx1_req | input | 1 | Fixed-vector request, level |
| fx0_req | input | 1 | Fixed-vector request, level |
| dev_req | input | 1 | Device-vectored request, level |
| insn_done | input | 1 | Instruction boundary marker |
| cmd_ei | input | 1 | Set global enable |
| cmd_di | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 3 | Mask value, 1 = masked |
| clr_fx2 | input | 1 | Clear FX2 pending latch |
| irq_o | output | 1 | Some source is eligible |
| bus_valid | input | 1 | Restart byte valid |
| bus_ready | output | 1 | Waiting for restart byte |
| bus_data | input | 8 | Restart opcode byte |
| ack_o | output | 1 | Acceptance strobe |
| vec_o | output | 16 | Service-routine address, zero when ack_o is low |
| src_o | output | 3 | Source code, zero when ack_o is low |

## Verification
The bench builds the block with its default parameters: a 16-bit address and the default fixed addresses. With these values all eight restart numbers map to addresses below 0x0040, so a random opcode byte reaches every DEV address. Random toggling of the five request lines, together with sparse enable, disable, mask and clear strobes, drives priority collisions and masked FX2 edges. The 50% boundary rate makes requests wait and fall away before service.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  localparam int unsigned NSRC = 5;
  localparam int unsigned NMASK = 3;
  localparam int unsigned SRC_W = 3;

  // Index order doubles as priority order (0 highest).
  localparam int unsigned IX_NMI = 0;
  localparam int unsigned IX_FX2 = 1;
  localparam int unsigned IX_FX1 = 2;
  localparam int unsigned IX_FX0 = 3;
  localparam int unsigned IX_DEV = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_FX2  = 3'd2,
    SRC_FX1  = 3'd3,
    SRC_FX0  = 3'd4,
    SRC_DEV  = 3'd5
  } src_e;
endpackage

// File: rtl/intvec_srcgate.sv
module intvec_srcgate
  import intvec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             fx2_req,
  input  logic             fx1_req,
  input  logic             fx0_req,
  input  logic             dev_req,
  input  logic             ie,
  input  logic [NMASK-1:0] mask,
  input  logic             clr_fx2,
  input  logic             take_nmi,
  input  logic             take_fx2,
  output logic [NSRC-1:0]  elig
);
  logic nmi_prev, nmi_arm, fx2_prev, fx2_pend;
  logic nmi_rise, fx2_rise;

  assign nmi_rise = nmi_req & ~nmi_prev;
  assign fx2_rise = fx2_req & ~fx2_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_arm  <= 1'b0;
      fx2_prev <= 1'b0;
      fx2_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_req;
      fx2_prev <= fx2_req;
      if (nmi_rise)                nmi_arm <= 1'b1;
      else if (!nmi_req || take_nmi) nmi_arm <= 1'b0;
      if (fx2_rise)                fx2_pend <= 1'b1;
      else if (clr_fx2 || take_fx2) fx2_pend <= 1'b0;
    end
  end

  always_comb begin
    elig         = '0;
    elig[IX_NMI] = nmi_arm & nmi_req;
    elig[IX_FX2] = fx2_pend & ~mask[2] & ie;
    elig[IX_FX1] = fx1_req & ~mask[1] & ie;
    elig[IX_FX0] = fx0_req & ~mask[0] & ie;
    elig[IX_DEV] = dev_req & ie;
  end
endmodule

// File: rtl/intvec_prio.sv
module intvec_prio #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant,
  output logic         any
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_top
        assign grant[i] = elig[i];
      end else begin : g_low
        assign grant[i] = elig[i] & ~(|elig[i-1:0]);
      end
    end
  endgenerate
  assign any = |elig;
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
  import intvec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OP_W    = 8,
  parameter int unsigned NMI_VEC = 'h24,
  parameter int unsigned FX2_VEC = 'h3C,
  parameter int unsigned FX1_VEC = 'h34,
  parameter int unsigned FX0_VEC = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic              fx2_req,
  input  logic              fx1_req,
  input  logic              fx0_req,
  input  logic              dev_req,
  input  logic              insn_done,
  input  logic              cmd_ei,
  input  logic              cmd_di,
  input  logic              mask_wr,
  input  logic [2:0]        mask_data,
  input  logic              clr_fx2,
  output logic              irq_o,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [OP_W-1:0]   bus_data,
  output logic              ack_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [2:0]        src_o
);
  localparam int unsigned PAD_W = ADDR_W - 6;

  logic             ie_q, wait_q;
  logic [NMASK-1:0] mask_q;
  logic [NSRC-1:0]  elig, grant;
  logic             any, take, take_mask, hs;
  logic [ADDR_W-1:0] fix_vec, dev_vec;
  src_e              fix_src;

  intvec_srcgate u_gate (
    .clk(clk), .rst_n(rst_n),
    .nmi_req(nmi_req), .fx2_req(fx2_req), .fx1_req(fx1_req),
    .fx0_req(fx0_req), .dev_req(dev_req),
    .ie(ie_q), .mask(mask_q), .clr_fx2(clr_fx2),
    .take_nmi(take & grant[IX_NMI]), .take_fx2(take & grant[IX_FX2]),
    .elig(elig)
  );

  intvec_prio #(.N(NSRC)) u_prio (.elig(elig), .grant(grant), .any(any));

  assign take      = insn_done & ~wait_q & any;
  assign take_mask = take & ~grant[IX_NMI];
  assign hs        = wait_q & bus_valid;
  assign irq_o     = any & ~wait_q;
  assign bus_ready = wait_q;
  assign dev_vec   = {{PAD_W{1'b0}}, bus_data[5:3], 3'b000};

  always_comb begin
    fix_vec = '0;
    fix_src = SRC_NONE;
    unique case (1'b1)
      grant[IX_NMI]: begin fix_vec = ADDR_W'(NMI_VEC); fix_src = SRC_NMI; end
      grant[IX_FX2]: begin fix_vec = ADDR_W'(FX2_VEC); fix_src = SRC_FX2; end
      grant[IX_FX1]: begin fix_vec = ADDR_W'(FX1_VEC); fix_src = SRC_FX1; end
      grant[IX_FX0]: begin fix_vec = ADDR_W'(FX0_VEC); fix_src = SRC_FX0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
      wait_q <= 1'b0;
      ack_o  <= 1'b0;
      vec_o  <= '0;
      src_o  <= SRC_NONE;
    end else begin
      if (take_mask)   ie_q <= 1'b0;
      else if (cmd_ei) ie_q <= 1'b1;
      else if (cmd_di) ie_q <= 1'b0;
      if (mask_wr) mask_q <= mask_data;
      if (take && grant[IX_DEV]) wait_q <= 1'b1;
      else if (hs)               wait_q <= 1'b0;
      if (hs) begin
        ack_o <= 1'b1;
        vec_o <= dev_vec;
        src_o <= SRC_DEV;
      end else if (take && !grant[IX_DEV]) begin
        ack_o <= 1'b1;
        vec_o <= fix_vec;
        src_o <= fix_src;
      end else begin
        ack_o <= 1'b0;
        vec_o <= '0;
        src_o <= SRC_NONE;
      end
    end
  end
endmodule

// File: rtl/intvec_chk.sv
module intvec_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              irq_o,
  input logic              ack_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [2:0]        src_o,
  input logic              ie_q
);
  p_ack_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($past(insn_done) || $past(bus_valid && bus_ready)));

  p_nmi_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && src_o == 3'd1) |-> (vec_o == ADDR_W'(16'h0024)));

  p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !irq_o);

  p_ie_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && src_o >= 3'd2 && src_o <= 3'd4) |-> !ie_q);

  p_ack_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (src_o != 3'd0));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (vec_o == '0 && src_o == 3'd0));
endmodule

bind intvec_ctrl intvec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .irq_o(irq_o), .ack_o(ack_o), .vec_o(vec_o),
  .src_o(src_o), .ie_q(ie_q)
);

// File: tb/intvec_ctrl_tb_top.sv
module intvec_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi_req, fx2_req, fx1_req, fx0_req, dev_req, insn_done;
  logic cmd_ei, cmd_di, mask_wr, clr_fx2, bus_valid;
  logic [2:0] mask_data;
  logic [7:0] bus_data;
  logic irq_o, bus_ready, ack_o;
  logic [15:0] vec_o;
  logic [2:0] src_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model state
  bit m_ie, m_wait, m_nprev, m_narm, m_fprev, m_pend, m_ack;
  bit [2:0] m_mask, m_src;
  bit [15:0] m_vec;

  always #10 clk = ~clk;

  intvec_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .fx2_req(fx2_req),
    .fx1_req(fx1_req), .fx0_req(fx0_req), .dev_req(dev_req),
    .insn_done(insn_done), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
    .mask_wr(mask_wr), .mask_data(mask_data), .clr_fx2(clr_fx2),
    .irq_o(irq_o), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_data(bus_data), .ack_o(ack_o), .vec_o(vec_o), .src_o(src_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    nmi_req = 0; fx2_req = 0; fx1_req = 0; fx0_req = 0; dev_req = 0;
    insn_done = 0; cmd_ei = 0; cmd_di = 0; mask_wr = 0; mask_data = 0;
    clr_fx2 = 0; bus_valid = 0; bus_data = 0;
  endtask

  function automatic string tag_of(bit [2:0] s);
    case (s)
      3'd1: return "R5";
      3'd2: return "R7";
      3'd3, 3'd4: return "R4";
      3'd5: return "R10";
      default: return "R9";
    endcase
  endfunction

  // One cycle: inputs already set; compare comb output, advance model, compare registered outputs.
  task automatic tick();
    bit [4:0] e, g;
    bit take, hs;
    bit [15:0] fv;
    bit [2:0] fs;
    #1;
    e[0] = m_narm & nmi_req;
    e[1] = m_pend & ~m_mask[2] & m_ie;
    e[2] = fx1_req & ~m_mask[1] & m_ie;
    e[3] = fx0_req & ~m_mask[0] & m_ie;
    e[4] = dev_req & m_ie;
    check("R2 irq", irq_o, (|e) & ~m_wait);
    g = 0;
    for (int i = 0; i < 5; i++) if (e[i] && g == 0) g[i] = 1'b1;
    take = insn_done & ~m_wait & (|e);
    hs = m_wait & bus_valid;
    fv = 0; fs = 0;
    if (g[0]) begin fv = 16'h0024; fs = 1; end
    else if (g[1]) begin fv = 16'h003C; fs = 2; end
    else if (g[2]) begin fv = 16'h0034; fs = 3; end
    else if (g[3]) begin fv = 16'h002C; fs = 4; end
    if (hs) begin m_ack = 1; m_vec = {10'd0, bus_data[5:3], 3'd0}; m_src = 5; end
    else if (take && !g[4]) begin m_ack = 1; m_vec = fv; m_src = fs; end
    else begin m_ack = 0; m_vec = 0; m_src = 0; end
    if (take && !g[0]) m_ie = 0;
    else if (cmd_ei) m_ie = 1;
    else if (cmd_di) m_ie = 0;
    if (mask_wr) m_mask = mask_data;
    if (take && g[4]) m_wait = 1; else if (hs) m_wait = 0;
    if (nmi_req && !m_nprev) m_narm = 1;
    else if (!nmi_req || (take && g[0])) m_narm = 0;
    if (fx2_req && !m_fprev) m_pend = 1;
    else if (clr_fx2 || (take && g[1])) m_pend = 0;
    m_nprev = nmi_req;
    m_fprev = fx2_req;
    @(posedge clk);
    #5;
    check({tag_of(m_src), " ack"}, ack_o, m_ack);
    check({tag_of(m_src), " vec"}, vec_o, m_vec);
    check({tag_of(m_src), " src"}, src_o, m_src);
    check("R10 ready", bus_ready, m_wait);
    idle_inputs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    rst_n = 0;
    m_ie = 0; m_wait = 0; m_nprev = 0; m_narm = 0; m_fprev = 0; m_pend = 0;
    m_ack = 0; m_mask = 3'b111; m_src = 0; m_vec = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    #1;
    check("R1 irq", irq_o, 0);
    check("R1 ack", ack_o, 0);
    check("R1 ready", bus_ready, 0);

    // R1: masks come up set
    cmd_ei = 1; tick();
    fx1_req = 1; insn_done = 1; tick();
    check("R1 masked", ack_o, 0);
    // R3: unmask FX1 via bit 1
    fx1_req = 1; mask_wr = 1; mask_data = 3'b101; tick();
    fx1_req = 1; insn_done = 1; tick();
    check("R4 fx1 vec", vec_o, 16'h0034);
    check("R3 unmask", ack_o, 1);
    fx1_req = 1; insn_done = 1; tick();
    check("R11 ie cleared", ack_o, 0);

    // R6 / R5: everything at once
    cmd_ei = 1; mask_wr = 1; mask_data = 3'b000; tick();
    nmi_req = 1; tick();
    nmi_req = 1; fx1_req = 1; fx0_req = 1; dev_req = 1; insn_done = 1; tick();
    check("R6 nmi wins", src_o, 1);
    check("R5 nmi vec", vec_o, 16'h0024);
    nmi_req = 1; fx0_req = 1; insn_done = 1; tick();
    check("R11 nmi keeps ie", src_o, 4);
    check("R5 no retrigger vec", vec_o, 16'h002C);

    // R7: FX2 edge remembered while masked
    cmd_ei = 1; mask_wr = 1; mask_data = 3'b100; tick();
    fx2_req = 1; tick();
    tick();
    insn_done = 1; tick();
    check("R7 masked hold", ack_o, 0);
    mask_wr = 1; mask_data = 3'b000; tick();
    insn_done = 1; tick();
    check("R7 fx2 fires", vec_o, 16'h003C);

    // R8: clear command drops latch
    cmd_ei = 1; mask_wr = 1; mask_data = 3'b100; tick();
    fx2_req = 1; tick();
    clr_fx2 = 1; tick();
    mask_wr = 1; mask_data = 3'b000; tick();
    insn_done = 1; tick();
    check("R8 cleared", ack_o, 0);

    // R10: device byte stream
    dev_req = 1; insn_done = 1; tick();
    check("R10 wait", bus_ready, 1);
    nmi_req = 1; insn_done = 1; tick();
    nmi_req = 1; insn_done = 1; tick();
    check("R10 no accept while waiting", ack_o, 0);
    bus_valid = 1; bus_data = 8'hDF; tick();
    check("R10 dev vec", vec_o, 16'h0018);
    check("R10 ready drop", bus_ready, 0);

    // R9: needs boundary
    cmd_ei = 1; tick();
    fx0_req = 1; tick();
    check("R9 no boundary", ack_o, 0);
    fx0_req = 1; insn_done = 1; tick();
    check("R9 boundary", ack_o, 1);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      bit [31:0] r;
      r = $urandom;
      nmi_req = (r[3:0] == 0) ? ~m_nprev : m_nprev;
      fx2_req = (r[7:4] < 3) ? ~m_fprev : m_fprev;
      fx1_req = r[8] & r[9];
      fx0_req = r[10] & r[11];
      dev_req = r[12] & r[13] & r[14];
      insn_done = r[15];
      cmd_ei = (r[18:16] == 0);
      cmd_di = (r[21:19] == 0) & r[22];
      mask_wr = (r[25:23] == 0);
      mask_data = $urandom;
      clr_fx2 = (r[29:26] == 0);
      bus_valid = r[30];
      bus_data = $urandom;
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule